// File: doc/BRIEF.md
# Tag-Steered Receive Queue Sorter

This block sits on a tile's network input port. It turns a stream of packets into a set of receive queues that the processor reads. A packet is a header word, then a tag word, then payload words. The header carries a length in bits [7:0], which counts the tag word plus the payload words. Software encodes the sending node, a stream number and a message type into the tag word. The block compares the whole 32-bit tag against one match register per dedicated queue. Each match register has its own enable. The packet, tag first, then goes into the matching dedicated queue. A tag that matches nothing sends the packet to a catch-all queue, and an interrupt is raised while that queue is non-empty. The header word itself is never stored.

Buffering is split statically. There are four dedicated queues of 24 words each and one catch-all queue of 32 words, which makes 128 words in total. Queue index 4 is the catch-all. The target queue is chosen when the tag word arrives. At that point the block checks that the queue has room for the whole rest of the packet. If it has not, the block holds `in_ready` low on the tag word until pops free enough space. A packet is therefore never split or dropped. Software must not send a packet longer than its target queue can hold.

The processor selects a queue with `pop_sel`. It sees the head word on `pop_data`, with `pop_valid` showing that the selected queue holds data, and it removes that word with `pop_req`.

The controller has three states:
- WAIT_HDR accepts a header. A non-zero length moves it to WAIT_TAG; a zero length keeps it in WAIT_HDR.
- WAIT_TAG chooses the queue and waits for room. When the tag is accepted it moves to WAIT_BODY, or back to WAIT_HDR if the length was 1.
- WAIT_BODY steers the payload and returns to WAIT_HDR after the last word.

Top module: `rx_tag_demux`

## Requirements
- R1: After reset all five queues are empty, `irq` is 0, `pop_valid` is 0 and `in_ready` is 1.
- R2: A packet whose tag equals an enabled match register is stored in that queue. The tag word is stored first, followed by the payload words in arrival order. The header word, whose length field is bits [7:0], is not stored.
- R3: When several enabled match registers equal the tag, the lowest-indexed queue receives the packet.
- R4: A queue whose enable is 0 never matches, even when its tag register equals the tag. An unmatched packet goes to the catch-all queue, index 4.
- R5: `irq` is high exactly while the catch-all queue holds at least one word. It rises after a miss is stored and falls when the last catch-all word is popped.
- R6: While the tag word is presented and the target queue has fewer free words than the header length, `in_ready` is 0. It returns to 1 once pops free enough room, and no word of any packet is lost.
- R7: `pop_valid` and `pop_data` show the head of the queue chosen by `pop_sel`. A `pop_req` to an empty queue changes no queue.
- R8: A push and a pop on the same queue in the same cycle both take effect, and word order is kept.
- R9: A header with length 0 is discarded, and the next word is treated as a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Network word valid |
| in_data | input | 32 | Network word |
| in_ready | output | 1 | Block accepts the word this cycle |
| cfg_we | input | 1 | Write one match register and its enable |
| cfg_sel | input | 2 | Dedicated queue being configured |
| cfg_en | input | 1 | Enable value written |
| cfg_tag | input | 32 | Tag value written |
| pop_sel | input | 3 | Queue to read (4 = catch-all) |
| pop_req | input | 1 | Remove the head of the selected queue |
| pop_valid | output | 1 | Selected queue is non-empty |
| pop_data | output | 32 | Head word of selected queue |
| q_nonempty | output | 5 | One bit per queue, set when it holds data |
| irq | output | 1 | Catch-all queue non-empty |

## Verification
Two functions can fall in the same cycle: a payload word being steered into a queue, and the processor popping that same queue. The bench provokes this by streaming a packet into one queue while a second thread pops that queue whenever `pop_valid` is high. Every popped word is compared in order against a model queue that was filled from the stimulus. The end state must show that queue empty, with nothing lost or duplicated. A second overlap is a pop that frees space while a tag word is stalled. The bench judges it by when `in_ready` rises and by the order of the words that follow.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [1:0] {
        WAIT_HDR  = 2'd0,
        WAIT_TAG  = 2'd1,
        WAIT_BODY = 2'd2
    } rxd_state_e;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 24,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rp];

    // R6: space is reserved per packet, so a push never meets a full queue
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)) || pop);
    // R7: pops are gated by the top, never reaching an empty queue
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/rxd_tag_match.sv
module rxd_tag_match #(
    parameter int W  = 32,
    parameter int NQ = 4,
    localparam int SW = $clog2(NQ + 1)
) (
    input  logic [W-1:0]  tag,
    input  logic [NQ-1:0] en,
    input  logic [W-1:0]  match_tag [NQ],
    output logic          hit,
    output logic [SW-1:0] sel
);
    always_comb begin
        hit = 1'b0;
        sel = SW'(NQ);
        for (int i = NQ - 1; i >= 0; i--) begin
            if (en[i] && (match_tag[i] == tag)) begin
                hit = 1'b1;
                sel = SW'(i);
            end
        end
    end
endmodule

// File: rtl/rx_tag_demux.sv
module rx_tag_demux
    import rxd_pkg::*;
#(
    parameter int W        = 32,
    parameter int NQ       = 4,
    parameter int DQ_DEPTH = 24,
    parameter int CA_DEPTH = 32,
    parameter int LEN_LSB  = 0,
    parameter int LEN_W    = 8,
    localparam int NT      = NQ + 1,
    localparam int SW      = $clog2(NT),
    localparam int CFW     = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int MAXD    = (DQ_DEPTH > CA_DEPTH) ? DQ_DEPTH : CA_DEPTH,
    localparam int CW      = $clog2(MAXD + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic           in_ready,
    input  logic           cfg_we,
    input  logic [CFW-1:0] cfg_sel,
    input  logic           cfg_en,
    input  logic [W-1:0]   cfg_tag,
    input  logic [SW-1:0]  pop_sel,
    input  logic           pop_req,
    output logic           pop_valid,
    output logic [W-1:0]   pop_data,
    output logic [NT-1:0]  q_nonempty,
    output logic           irq
);
    rxd_state_e       state, state_nx;
    logic [LEN_W-1:0] rem, rem_nx;
    logic [SW-1:0]    tgt, tgt_nx;

    logic [NQ-1:0]    en_r;
    logic [W-1:0]     tag_r [NQ];

    logic             hit;
    logic [SW-1:0]    msel;
    logic [NT-1:0]    push_v, pop_v;
    logic [W-1:0]     rdata [NT];
    logic [CW-1:0]    cnt  [NT];
    logic [CW-1:0]    free [NT];
    logic [LEN_W-1:0] hdr_len;

    assign hdr_len = in_data[LEN_LSB +: LEN_W];

    // match registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r <= '0;
            for (int i = 0; i < NQ; i++) tag_r[i] <= '0;
        end else if (cfg_we) begin
            en_r[cfg_sel]  <= cfg_en;
            tag_r[cfg_sel] <= cfg_tag;
        end
    end

    rxd_tag_match #(.W(W), .NQ(NQ)) u_match (
        .tag(in_data), .en(en_r), .match_tag(tag_r), .hit(hit), .sel(msel)
    );

    // queue storage: dedicated queues and one catch-all
    for (genvar g = 0; g < NT; g++) begin : g_q
        localparam int D  = (g == NQ) ? CA_DEPTH : DQ_DEPTH;
        localparam int QC = $clog2(D + 1);
        logic [QC-1:0] c;
        rxd_fifo #(.W(W), .DEPTH(D)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_v[g]), .wr_data(in_data),
            .pop(pop_v[g]), .rd_data(rdata[g]), .count(c)
        );
        assign cnt[g]        = CW'(c);
        assign free[g]       = CW'(D) - CW'(c);
        assign q_nonempty[g] = (c != '0);
        assign pop_v[g]      = pop_req && (pop_sel == SW'(g)) && (c != '0);
    end

    assign pop_valid = (32'(pop_sel) < NT) ? q_nonempty[pop_sel] : 1'b0;
    assign pop_data  = (32'(pop_sel) < NT) ? rdata[pop_sel] : '0;
    assign irq       = q_nonempty[NQ];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WAIT_HDR;
            rem   <= '0;
            tgt   <= '0;
        end else begin
            state <= state_nx;
            rem   <= rem_nx;
            tgt   <= tgt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        rem_nx   = rem;
        tgt_nx   = tgt;
        in_ready = 1'b0;
        push_v   = '0;
        unique case (state)
            WAIT_HDR: begin
                in_ready = 1'b1;
                if (in_valid && hdr_len != '0) begin
                    rem_nx   = hdr_len;
                    state_nx = WAIT_TAG;
                end
            end
            WAIT_TAG: begin
                in_ready = (32'(free[msel]) >= 32'(rem));
                if (in_valid && in_ready) begin
                    push_v[msel] = 1'b1;
                    tgt_nx       = msel;
                    rem_nx       = rem - 1'b1;
                    state_nx     = (rem == LEN_W'(1)) ? WAIT_HDR : WAIT_BODY;
                end
            end
            WAIT_BODY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    push_v[tgt] = 1'b1;
                    rem_nx      = rem - 1'b1;
                    if (rem == LEN_W'(1)) state_nx = WAIT_HDR;
                end
            end
            default: state_nx = WAIT_HDR;
        endcase
    end

    // R6: a reserved packet body always finds room in its queue
    a_r6_body_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        state == WAIT_BODY |-> free[tgt] != '0);
    // R4: a dedicated hit always points at an enabled queue
    a_r4_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_TAG && in_valid && in_ready && hit) |-> en_r[msel[CFW-1:0]]);
    // R5: a stored miss raises the interrupt on the next cycle
    a_r5_irq_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_TAG && in_valid && in_ready && !hit) |=> irq);
    // R9: a zero-length header leaves the controller waiting for a header
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_HDR && in_valid && hdr_len == '0) |=> state == WAIT_HDR);
endmodule

// File: tb/rx_tag_demux_tb.sv
module rx_tag_demux_tb;
    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0;
    logic [31:0] in_data = 0;
    logic        in_ready;
    logic        cfg_we = 0, cfg_en = 0;
    logic [1:0]  cfg_sel = 0;
    logic [31:0] cfg_tag = 0;
    logic [2:0]  pop_sel = 0;
    logic        pop_req = 0;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic [4:0]  q_nonempty;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q [5][$];

    always #10 clk = ~clk;

    rx_tag_demux u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .cfg_tag(cfg_tag), .pop_sel(pop_sel), .pop_req(pop_req),
        .pop_valid(pop_valid), .pop_data(pop_data), .q_nonempty(q_nonempty), .irq(irq)
    );

    localparam logic [31:0] TAG_A = 32'h0003_1105;
    localparam logic [31:0] TAG_B = 32'h0007_2201;
    localparam logic [31:0] TAG_D = 32'h000C_0F02;
    localparam logic [31:0] TAG_X = 32'h0009_9999;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input int q, input bit en, input logic [31:0] t);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(q); cfg_en = en; cfg_tag = t;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1; in_data = w;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic send_pkt(input logic [31:0] tag, input int nd, input int q);
        exp_q[q].push_back(tag);
        for (int i = 0; i < nd; i++) exp_q[q].push_back(tag ^ (32'h100 * (i + 1)));
        send_word(32'hBEEF_0000 | 32'(nd + 1));
        send_word(tag);
        for (int i = 0; i < nd; i++) send_word(tag ^ (32'h100 * (i + 1)));
    endtask

    task automatic pop_wait(input int q, input string req);
        logic [31:0] e;
        @(negedge clk);
        pop_sel = 3'(q);
        #1;
        for (int k = 0; k < 200 && !pop_valid; k++) begin @(negedge clk); #1; end
        e = (exp_q[q].size() != 0) ? exp_q[q].pop_front() : 32'hDEAD_DEAD;
        chk(pop_valid === 1'b1 && pop_data === e, req, pop_data, e);
        pop_req = 1;
        @(posedge clk); #1;
        pop_req = 0;
    endtask

    task automatic drain(input int q, input string req);
        while (exp_q[q].size() != 0) pop_wait(q, req);
        @(negedge clk); #1;
        chk(q_nonempty[q] === 1'b0, req, 32'(q_nonempty), 0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
        chk(q_nonempty === 5'b0, "R1 queues", 32'(q_nonempty), 0);
        chk(pop_valid === 1'b0, "R1 pop_valid", 32'(pop_valid), 0);
    endtask

    task automatic t_basic;
        send_pkt(TAG_A, 4, 0);
        @(negedge clk); #1;
        chk(q_nonempty === 5'b00001, "R2 only q0", 32'(q_nonempty), 1);
        drain(0, "R2 order");
    endtask

    task automatic t_priority;
        send_pkt(TAG_B, 3, 1);
        @(negedge clk); #1;
        chk(q_nonempty === 5'b00010, "R3 lowest wins", 32'(q_nonempty), 2);
        drain(1, "R3 data");
    endtask

    task automatic t_miss;
        send_pkt(TAG_D, 2, 4);
        @(negedge clk); #1;
        chk(q_nonempty === 5'b10000, "R4 disabled to catch-all", 32'(q_nonempty), 16);
        chk(irq === 1'b1, "R5 irq raised", 32'(irq), 1);
        pop_wait(4, "R4 tag first");
        pop_wait(4, "R4 data");
        @(negedge clk); #1;
        chk(irq === 1'b1, "R5 irq held", 32'(irq), 1);
        pop_wait(4, "R4 data");
        @(negedge clk); #1;
        chk(irq === 1'b0, "R5 irq cleared", 32'(irq), 0);
        send_pkt(TAG_X, 0, 4);
        @(negedge clk); #1;
        chk(irq === 1'b1, "R5 unknown tag", 32'(irq), 1);
        drain(4, "R5 drain");
    endtask

    task automatic t_empty_pop;
        send_pkt(TAG_A, 1, 0);
        @(negedge clk);
        pop_sel = 3; #1;
        chk(pop_valid === 1'b0, "R7 empty valid", 32'(pop_valid), 0);
        pop_req = 1;
        @(posedge clk); #1;
        pop_req = 0;
        @(negedge clk); #1;
        chk(q_nonempty === 5'b00001, "R7 empty pop no effect", 32'(q_nonempty), 1);
        drain(0, "R7 q0 intact");
    endtask

    task automatic t_zero_len;
        send_word(32'hBEEF_0000);
        send_pkt(TAG_B, 2, 1);
        @(negedge clk); #1;
        chk(q_nonempty === 5'b00010, "R9 zero header skipped", 32'(q_nonempty), 2);
        drain(1, "R9 data");
    endtask

    task automatic t_stall;
        send_pkt(TAG_A, 16, 0);
        exp_q[0].push_back(TAG_A);
        for (int i = 0; i < 9; i++) exp_q[0].push_back(32'h5500_0000 + 32'(i));
        send_word(32'hBEEF_000A);
        @(negedge clk);
        in_valid = 1; in_data = TAG_A;
        #1;
        chk(in_ready === 1'b0, "R6 stall on tag", 32'(in_ready), 0);
        pop_wait(0, "R6 pop");
        pop_wait(0, "R6 pop");
        @(negedge clk); #1;
        chk(in_ready === 1'b0, "R6 still short", 32'(in_ready), 0);
        pop_wait(0, "R6 pop");
        @(negedge clk); #1;
        chk(in_ready === 1'b1, "R6 released", 32'(in_ready), 1);
        @(posedge clk); #1;
        in_valid = 0;
        for (int i = 0; i < 9; i++) send_word(32'h5500_0000 + 32'(i));
        drain(0, "R6 nothing lost");
    endtask

    task automatic t_overlap;
        fork
            send_pkt(TAG_B, 12, 1);
            begin
                repeat (3) @(posedge clk);
                for (int i = 0; i < 13; i++) pop_wait(1, "R8 push+pop");
            end
        join
        @(negedge clk); #1;
        chk(q_nonempty === 5'b0 && exp_q[1].size() == 0, "R8 balanced", 32'(q_nonempty), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        cfg(0, 1, TAG_A);
        cfg(1, 1, TAG_B);
        cfg(2, 1, TAG_B);
        cfg(3, 0, TAG_D);
        t_basic();
        t_priority();
        t_miss();
        t_empty_pop();
        t_zero_len();
        t_stall();
        t_overlap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule